// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the per-channel transfer state of a multi-channel DMA controller. Every channel owns a current address, a current byte count, and base copies of both. Software programs a channel through three load strobes: one for the direction and auto-reload mode bits, one for the address and one for the count. Each load of the address or the count writes the base register and the current register together. A transfer request names a channel. When the channel is enabled, the engine emits that channel's current address one cycle later, then steps the address up or down and decrements the count.

A count is programmed as the byte total minus one. The transfer made while the count is zero is the terminal one. At that point the channel flags terminal count and sets its sticky status bit. It then either reloads its current registers from the base registers, or masks itself until software loads a new count. In memory-to-memory mode, channels 0 and 1 act as one pair: channel 0 gives the source address, channel 1 gives the destination address and the byte count, and one request moves one byte.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset every channel is masked (mask_o all ones), every terminal-count status bit is clear, out_valid_o is low, and all address, count and mode registers are zero.
- R2: A load of a channel's address writes its base and current address. A load of its count writes the base and current count, clears that channel's mask bit and clears its terminal-count status bit. A mode load sets the direction bit (1 = down) and the auto-reload bit (1 = on).
- R3: An accepted single-channel request produces exactly one output on the next cycle: out_valid_o=1, out_ch_o=channel, out_pair_o=0, out_dst_o=0, and out_src_o=the channel's current address. The address then moves by +1 (direction 0) or -1 (direction 1), wrapping modulo 2^16.
- R4: The count is loaded as N-1 and drops by one on each transfer. The transfer made with a count of 0 is terminal: out_tc_o=1 with that output, and the channel's tc_stat_o bit is set and stays set.
- R5: With auto-reload on, a terminal transfer copies the base address and base count back into the current registers, and the channel stays unmasked.
- R6: With auto-reload off, a terminal transfer sets the channel's mask bit (the address still steps and the count wraps to all ones). Requests to a masked channel give no output and change no state.
- R7: A request made in a cycle in which any load strobe is high is ignored.
- R8: With m2m_en_i=1, a request naming channel 0 or 1 is served only if both are unmasked. It gives one paired output: out_pair_o=1, out_ch_o=1, out_src_o=channel 0 address, out_dst_o=channel 1 address. Both addresses then step in their own directions, and only channel 1's count decrements.
- R9: The terminal event of a pair comes from channel 1's count. It sets the status bits of both channels, and each of the two channels then reloads or masks itself according to its own auto-reload bit.
- R10: While m2m_en_i=1, requests to channels other than 0 and 1 are served as single-channel transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_addr_i | input | 1 | Load address strobe |
| ld_cnt_i | input | 1 | Load count strobe (value is bytes minus one) |
| ld_mode_i | input | 1 | Load mode bits strobe |
| ld_ch_i | input | CHW (2) | Channel addressed by a load |
| ld_data_i | input | DW (16) | Load data |
| ld_down_i | input | 1 | Mode: address steps down when 1 |
| ld_auto_i | input | 1 | Mode: auto-reload at terminal count when 1 |
| m2m_en_i | input | 1 | Memory-to-memory pairing of channels 0 and 1 |
| req_i | input | 1 | Transfer request |
| req_ch_i | input | CHW (2) | Requested channel |
| out_valid_o | output | 1 | A transfer was performed |
| out_ch_o | output | CHW (2) | Channel whose count was used |
| out_pair_o | output | 1 | Output is a memory-to-memory pair transfer |
| out_src_o | output | AW (16) | Transfer (source) address |
| out_dst_o | output | AW (16) | Destination address for a pair, else zero |
| out_tc_o | output | 1 | This transfer was terminal |
| mask_o | output | NCH (4) | Per-channel mask bits |
| tc_stat_o | output | NCH (4) | Sticky per-channel terminal-count status |

## Verification
A wrong address step or a corrupted current address shows up on out_src_o or out_dst_o at the very next transfer of that channel. A wrong count does not show at once: it appears only as an out_tc_o flag on the wrong transfer, so it is caught at the byte where the terminal event should occur, up to N transfers later. A missing reload or mask shows on the transfer after the terminal one, either as an address that continues instead of returning to the base value, or as an output that should not be there. A scoreboard compares every output with an independent model of the channel state, and the mask and status bits are compared after each programming and terminal step.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

   typedef enum logic [1:0] {
      STEP_IDLE = 2'd0,
      STEP_SOLO = 2'd1,
      STEP_PAIR = 2'd2
   } step_kind_e;

   localparam int unsigned PAIR_SRC_CH = 0;
   localparam int unsigned PAIR_DST_CH = 1;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
   parameter int unsigned AW = 16,
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_addr_i,
   input  logic          wr_cnt_i,
   input  logic          wr_mode_i,
   input  logic [AW-1:0] addr_data_i,
   input  logic [CW-1:0] cnt_data_i,
   input  logic          mode_down_i,
   input  logic          mode_auto_i,
   input  logic          adv_addr_i,
   input  logic          adv_cnt_i,
   input  logic          pair_tc_i,
   output logic [AW-1:0] cur_addr_o,
   output logic          cnt_zero_o,
   output logic          mask_o,
   output logic          tc_flag_o
);

   logic [AW-1:0] base_addr_q, cur_addr_q, addr_next;
   logic [CW-1:0] base_cnt_q,  cur_cnt_q,  cnt_next;
   logic          down_q, auto_q, mask_q, tcf_q;
   logic          tc_event, active;

   assign cnt_zero_o = (cur_cnt_q == '0);
   assign tc_event   = (adv_cnt_i && cnt_zero_o) || pair_tc_i;
   assign active     = adv_addr_i || adv_cnt_i || pair_tc_i;

   always_comb begin
      addr_next = cur_addr_q;
      cnt_next  = cur_cnt_q;
      if (adv_addr_i) begin
         addr_next = down_q ? (cur_addr_q - 1'b1) : (cur_addr_q + 1'b1);
      end
      if (adv_cnt_i) begin
         cnt_next = cur_cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_addr_q <= '0;
         cur_addr_q  <= '0;
         base_cnt_q  <= '0;
         cur_cnt_q   <= '0;
         down_q      <= 1'b0;
         auto_q      <= 1'b0;
         mask_q      <= 1'b1;
         tcf_q       <= 1'b0;
      end else begin
         if (wr_mode_i) begin
            down_q <= mode_down_i;
            auto_q <= mode_auto_i;
         end
         if (wr_addr_i) begin
            base_addr_q <= addr_data_i;
            cur_addr_q  <= addr_data_i;
         end
         if (wr_cnt_i) begin
            base_cnt_q <= cnt_data_i;
            cur_cnt_q  <= cnt_data_i;
            mask_q     <= 1'b0;
            tcf_q      <= 1'b0;
         end
         if (active) begin
            if (tc_event && auto_q) begin
               cur_addr_q <= base_addr_q;
               cur_cnt_q  <= base_cnt_q;
            end else begin
               cur_addr_q <= addr_next;
               cur_cnt_q  <= cnt_next;
            end
            if (tc_event) begin
               tcf_q <= 1'b1;
               if (!auto_q) begin
                  mask_q <= 1'b1;
               end
            end
         end
      end
   end

   assign cur_addr_o = cur_addr_q;
   assign mask_o     = mask_q;
   assign tc_flag_o  = tcf_q;

endmodule

// File: rtl/dma_step_ctrl.sv
module dma_step_ctrl
   import dma_eng_pkg::*;
#(
   parameter int unsigned NCH = 4,
   localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           req_i,
   input  logic [CHW-1:0] req_ch_i,
   input  logic           m2m_i,
   input  logic           any_ld_i,
   input  logic [NCH-1:0] mask_i,
   input  logic [NCH-1:0] zero_i,
   output logic [NCH-1:0] adv_addr_o,
   output logic [NCH-1:0] adv_cnt_o,
   output logic [NCH-1:0] pair_tc_o,
   output step_kind_e     kind_o,
   output logic           tc_o,
   output logic [CHW-1:0] ch_o
);

   logic pair_sel;
   assign pair_sel = m2m_i && (int'(req_ch_i) <= int'(PAIR_DST_CH));

   always_comb begin
      adv_addr_o = '0;
      adv_cnt_o  = '0;
      pair_tc_o  = '0;
      kind_o     = STEP_IDLE;
      tc_o       = 1'b0;
      ch_o       = req_ch_i;
      if (req_i && !any_ld_i) begin
         if (pair_sel) begin
            if (!mask_i[PAIR_SRC_CH] && !mask_i[PAIR_DST_CH]) begin
               kind_o                  = STEP_PAIR;
               adv_addr_o[PAIR_SRC_CH] = 1'b1;
               adv_addr_o[PAIR_DST_CH] = 1'b1;
               adv_cnt_o[PAIR_DST_CH]  = 1'b1;
               pair_tc_o[PAIR_SRC_CH]  = zero_i[PAIR_DST_CH];
               tc_o                    = zero_i[PAIR_DST_CH];
               ch_o                    = CHW'(PAIR_DST_CH);
            end
         end else if (!mask_i[req_ch_i]) begin
            kind_o               = STEP_SOLO;
            adv_addr_o[req_ch_i] = 1'b1;
            adv_cnt_o[req_ch_i]  = 1'b1;
            tc_o                 = zero_i[req_ch_i];
         end
      end
   end

endmodule

// File: rtl/dma_out_stage.sv
module dma_out_stage
   import dma_eng_pkg::*;
#(
   parameter int unsigned NCH = 4,
   parameter int unsigned AW  = 16,
   localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  step_kind_e             kind_i,
   input  logic [CHW-1:0]         ch_i,
   input  logic [CHW-1:0]         req_ch_i,
   input  logic                   tc_i,
   input  logic [NCH-1:0][AW-1:0] addr_i,
   output logic                   valid_o,
   output logic [CHW-1:0]         ch_o,
   output logic                   pair_o,
   output logic [AW-1:0]          src_o,
   output logic [AW-1:0]          dst_o,
   output logic                   tc_o
);

   logic [AW-1:0] src_sel, dst_sel;

   always_comb begin
      if (kind_i == STEP_PAIR) begin
         src_sel = addr_i[PAIR_SRC_CH];
         dst_sel = addr_i[PAIR_DST_CH];
      end else begin
         src_sel = addr_i[req_ch_i];
         dst_sel = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         ch_o    <= '0;
         pair_o  <= 1'b0;
         src_o   <= '0;
         dst_o   <= '0;
         tc_o    <= 1'b0;
      end else begin
         valid_o <= (kind_i != STEP_IDLE);
         ch_o    <= ch_i;
         pair_o  <= (kind_i == STEP_PAIR);
         src_o   <= (kind_i != STEP_IDLE) ? src_sel : '0;
         dst_o   <= dst_sel;
         tc_o    <= (kind_i != STEP_IDLE) && tc_i;
      end
   end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
   import dma_eng_pkg::*;
#(
   parameter int unsigned NCH = 4,
   parameter int unsigned AW  = 16,
   parameter int unsigned CW  = 16,
   localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int unsigned DW  = (AW > CW) ? AW : CW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld_addr_i,
   input  logic           ld_cnt_i,
   input  logic           ld_mode_i,
   input  logic [CHW-1:0] ld_ch_i,
   input  logic [DW-1:0]  ld_data_i,
   input  logic           ld_down_i,
   input  logic           ld_auto_i,
   input  logic           m2m_en_i,
   input  logic           req_i,
   input  logic [CHW-1:0] req_ch_i,
   output logic           out_valid_o,
   output logic [CHW-1:0] out_ch_o,
   output logic           out_pair_o,
   output logic [AW-1:0]  out_src_o,
   output logic [AW-1:0]  out_dst_o,
   output logic           out_tc_o,
   output logic [NCH-1:0] mask_o,
   output logic [NCH-1:0] tc_stat_o
);

   generate
      if (NCH < 2 || (1 << CHW) != NCH) begin : g_bad_nch
         $error("dma_xfer_engine: NCH must be a power of two and at least 2");
      end
      if (AW < 2 || CW < 1) begin : g_bad_width
         $error("dma_xfer_engine: AW must be >= 2 and CW >= 1");
      end
   endgenerate

   logic                   any_ld;
   logic [NCH-1:0][AW-1:0] cur_addr;
   logic [NCH-1:0]         cnt_zero, chan_mask, chan_tcf;
   logic [NCH-1:0]         adv_addr, adv_cnt, pair_tc;
   step_kind_e             kind;
   logic                   step_tc;
   logic [CHW-1:0]         step_ch;

   assign any_ld = ld_addr_i || ld_cnt_i || ld_mode_i;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      logic sel;
      assign sel = (ld_ch_i == CHW'(c));
      dma_chan_regs #(.AW(AW), .CW(CW)) regs_i (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr_addr_i   (ld_addr_i && sel),
         .wr_cnt_i    (ld_cnt_i && sel),
         .wr_mode_i   (ld_mode_i && sel),
         .addr_data_i (ld_data_i[AW-1:0]),
         .cnt_data_i  (ld_data_i[CW-1:0]),
         .mode_down_i (ld_down_i),
         .mode_auto_i (ld_auto_i),
         .adv_addr_i  (adv_addr[c]),
         .adv_cnt_i   (adv_cnt[c]),
         .pair_tc_i   (pair_tc[c]),
         .cur_addr_o  (cur_addr[c]),
         .cnt_zero_o  (cnt_zero[c]),
         .mask_o      (chan_mask[c]),
         .tc_flag_o   (chan_tcf[c])
      );
   end

   dma_step_ctrl #(.NCH(NCH)) ctrl_i (
      .req_i      (req_i),
      .req_ch_i   (req_ch_i),
      .m2m_i      (m2m_en_i),
      .any_ld_i   (any_ld),
      .mask_i     (chan_mask),
      .zero_i     (cnt_zero),
      .adv_addr_o (adv_addr),
      .adv_cnt_o  (adv_cnt),
      .pair_tc_o  (pair_tc),
      .kind_o     (kind),
      .tc_o       (step_tc),
      .ch_o       (step_ch)
   );

   dma_out_stage #(.NCH(NCH), .AW(AW)) out_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind_i   (kind),
      .ch_i     (step_ch),
      .req_ch_i (req_ch_i),
      .tc_i     (step_tc),
      .addr_i   (cur_addr),
      .valid_o  (out_valid_o),
      .ch_o     (out_ch_o),
      .pair_o   (out_pair_o),
      .src_o    (out_src_o),
      .dst_o    (out_dst_o),
      .tc_o     (out_tc_o)
   );

   assign mask_o    = chan_mask;
   assign tc_stat_o = chan_tcf;

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
   parameter int unsigned NCH = 4,
   parameter int unsigned AW  = 16,
   parameter int unsigned CHW = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           ld_addr_i,
   input logic           ld_cnt_i,
   input logic           ld_mode_i,
   input logic [CHW-1:0] ld_ch_i,
   input logic           m2m_en_i,
   input logic           req_i,
   input logic [CHW-1:0] req_ch_i,
   input logic           out_valid_o,
   input logic [CHW-1:0] out_ch_o,
   input logic           out_pair_o,
   input logic [AW-1:0]  out_dst_o,
   input logic           out_tc_o,
   input logic [NCH-1:0] mask_o,
   input logic [NCH-1:0] tc_stat_o
);

   p_out_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> $past(req_i));

   p_load_blocks_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && (ld_addr_i || ld_cnt_i || ld_mode_i)) |=> !out_valid_o);

   p_masked_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !m2m_en_i && mask_o[req_ch_i]) |=> !out_valid_o);

   p_tc_sets_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_tc_o |-> tc_stat_o[out_ch_o]);

   p_cnt_load_enables_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_cnt_i |=> (!mask_o[$past(ld_ch_i)] && !tc_stat_o[$past(ld_ch_i)]));

   p_pair_tagging_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (out_pair_o ? (out_ch_o == CHW'(1)) : (out_dst_o == '0)));

   p_pair_tc_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_tc_o && out_pair_o) |-> (tc_stat_o[0] && tc_stat_o[1]));

endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.NCH(NCH), .AW(AW), .CHW(CHW)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .ld_addr_i   (ld_addr_i),
   .ld_cnt_i    (ld_cnt_i),
   .ld_mode_i   (ld_mode_i),
   .ld_ch_i     (ld_ch_i),
   .m2m_en_i    (m2m_en_i),
   .req_i       (req_i),
   .req_ch_i    (req_ch_i),
   .out_valid_o (out_valid_o),
   .out_ch_o    (out_ch_o),
   .out_pair_o  (out_pair_o),
   .out_dst_o   (out_dst_o),
   .out_tc_o    (out_tc_o),
   .mask_o      (mask_o),
   .tc_stat_o   (tc_stat_o)
);

// File: tb/dma_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module dma_xfer_engine_tb_top;

   typedef struct packed {
      logic [1:0]  ch;
      logic        pair;
      logic [15:0] src;
      logic [15:0] dst;
      logic        tc;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_addr_i = 0, ld_cnt_i = 0, ld_mode_i = 0;
   logic [1:0]  ld_ch_i = 0;
   logic [15:0] ld_data_i = 0;
   logic        ld_down_i = 0, ld_auto_i = 0, m2m_en_i = 0;
   logic        req_i = 0;
   logic [1:0]  req_ch_i = 0;
   logic        out_valid_o, out_pair_o, out_tc_o;
   logic [1:0]  out_ch_o;
   logic [15:0] out_src_o, out_dst_o;
   logic [3:0]  mask_o, tc_stat_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   exp_t q[$];

   logic [15:0] m_addr[4], m_cnt[4], m_baddr[4], m_bcnt[4];
   bit m_down[4], m_auto[4], m_mask[4], m_stat[4];

   always #4 clk = ~clk;

   dma_xfer_engine dut_i (
      .clk(clk), .rst_n(rst_n), .ld_addr_i(ld_addr_i), .ld_cnt_i(ld_cnt_i),
      .ld_mode_i(ld_mode_i), .ld_ch_i(ld_ch_i), .ld_data_i(ld_data_i),
      .ld_down_i(ld_down_i), .ld_auto_i(ld_auto_i), .m2m_en_i(m2m_en_i),
      .req_i(req_i), .req_ch_i(req_ch_i), .out_valid_o(out_valid_o),
      .out_ch_o(out_ch_o), .out_pair_o(out_pair_o), .out_src_o(out_src_o),
      .out_dst_o(out_dst_o), .out_tc_o(out_tc_o), .mask_o(mask_o),
      .tc_stat_o(tc_stat_o)
   );

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   function automatic logic [3:0] pack_mask();
      return {m_mask[3], m_mask[2], m_mask[1], m_mask[0]};
   endfunction

   function automatic logic [3:0] pack_stat();
      return {m_stat[3], m_stat[2], m_stat[1], m_stat[0]};
   endfunction

   // model of one channel at a terminal or ordinary step (R3-R6, R9)
   task automatic model_step(input int c, input bit tc, input bit use_cnt);
      if (tc) begin
         m_stat[c] = 1;
         if (m_auto[c]) begin
            m_addr[c] = m_baddr[c];
            m_cnt[c]  = m_bcnt[c];
            return;
         end
         m_mask[c] = 1;
      end
      m_addr[c] = m_down[c] ? m_addr[c] - 16'd1 : m_addr[c] + 16'd1;
      if (use_cnt) m_cnt[c] = m_cnt[c] - 16'd1;
   endtask

   task automatic prog(input int c, input logic [15:0] a, input int n, input bit dn, input bit au);
      @(negedge clk);
      ld_mode_i = 1; ld_ch_i = 2'(c); ld_down_i = dn; ld_auto_i = au;
      @(negedge clk);
      ld_mode_i = 0; ld_addr_i = 1; ld_data_i = a;
      @(negedge clk);
      ld_addr_i = 0; ld_cnt_i = 1; ld_data_i = 16'(n - 1);
      @(negedge clk);
      ld_cnt_i = 0;
      m_down[c] = dn; m_auto[c] = au;
      m_addr[c] = a; m_baddr[c] = a;
      m_cnt[c] = 16'(n - 1); m_bcnt[c] = 16'(n - 1);
      m_mask[c] = 0; m_stat[c] = 0;
      chk(mask_o == pack_mask(), "R2 mask after count load", 64'(mask_o), 64'(pack_mask()));
      chk(tc_stat_o == pack_stat(), "R2 status after count load", 64'(tc_stat_o), 64'(pack_stat()));
   endtask

   task automatic do_req(input int c, input bit with_ld);
      exp_t e;
      bit tc;
      @(negedge clk);
      req_i = 1; req_ch_i = 2'(c);
      if (with_ld) begin
         ld_mode_i = 1; ld_ch_i = 2'(c); ld_down_i = m_down[c]; ld_auto_i = m_auto[c];
      end
      if (!with_ld) begin
         if (m2m_en_i && c < 2) begin
            if (!m_mask[0] && !m_mask[1]) begin
               tc = (m_cnt[1] == 16'd0);
               e.ch = 2'd1; e.pair = 1; e.src = m_addr[0]; e.dst = m_addr[1]; e.tc = tc;
               q.push_back(e);
               model_step(0, tc, 0);
               model_step(1, tc, 1);
            end
         end else if (!m_mask[c]) begin
            tc = (m_cnt[c] == 16'd0);
            e.ch = 2'(c); e.pair = 0; e.src = m_addr[c]; e.dst = 16'd0; e.tc = tc;
            q.push_back(e);
            model_step(c, tc, 1);
         end
      end
      @(negedge clk);
      req_i = 0; ld_mode_i = 0;
      #1;
      chk(q.size() == 0, "R3/R6/R7 output count per request", 64'(q.size()), 64'd0);
      q.delete();
      chk(mask_o == pack_mask(), "R5/R6/R9 mask bits", 64'(mask_o), 64'(pack_mask()));
      chk(tc_stat_o == pack_stat(), "R4/R9 status bits", 64'(tc_stat_o), 64'(pack_stat()));
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid_o) begin
         if (q.size() == 0) begin
            chk(0, "R6/R7 unexpected output", 64'(out_src_o), 64'd0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(out_src_o == e.src, e.pair ? "R8 source address" : "R3 address", 64'(out_src_o), 64'(e.src));
            chk(out_dst_o == e.dst, "R8 destination address", 64'(out_dst_o), 64'(e.dst));
            chk(out_tc_o == e.tc, "R4 terminal flag", 64'(out_tc_o), 64'(e.tc));
            chk(out_pair_o == e.pair && out_ch_o == e.ch, "R8/R10 channel tag",
                64'({out_pair_o, out_ch_o}), 64'({e.pair, e.ch}));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         m_addr[i] = 0; m_cnt[i] = 0; m_baddr[i] = 0; m_bcnt[i] = 0;
         m_down[i] = 0; m_auto[i] = 0; m_mask[i] = 1; m_stat[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(mask_o == 4'hF, "R1 masks after reset", 64'(mask_o), 64'hF);
      chk(tc_stat_o == 4'h0, "R1 status after reset", 64'(tc_stat_o), 64'h0);
      chk(out_valid_o == 1'b0, "R1 no output after reset", 64'(out_valid_o), 64'h0);
      // R1/R6: masked channel ignores requests
      do_req(2, 0);

      // R3/R4/R6: ch2 up, 3 bytes, no reload
      prog(2, 16'h1000, 3, 0, 0);
      do_req(2, 0);
      do_req(2, 0);
      do_req(2, 0);
      do_req(2, 0);   // masked now: no output

      // R5: ch3 down, 2 bytes, auto reload
      prog(3, 16'h0001, 2, 1, 1);
      do_req(3, 0);
      do_req(3, 0);
      do_req(3, 0);

      // R3 address wrap down and up
      prog(1, 16'h0000, 1, 1, 0);
      do_req(1, 0);
      prog(0, 16'hFFFF, 2, 0, 0);
      do_req(0, 0);
      do_req(0, 0);

      // R7: request with a load in the same cycle is ignored
      prog(2, 16'h4000, 4, 0, 0);
      do_req(2, 1);
      do_req(2, 0);

      // R8/R9/R10: memory-to-memory pair
      prog(0, 16'h2000, 5, 0, 0);
      prog(1, 16'h3000, 2, 1, 1);
      @(negedge clk);
      m2m_en_i = 1;
      do_req(0, 0);
      do_req(1, 0);
      do_req(0, 0);   // ch0 masked after pair terminal: ignored
      do_req(2, 0);   // R10 single transfer while paired
      prog(0, 16'h5000, 3, 0, 0);
      do_req(1, 0);
      m2m_en_i = 0;
      do_req(1, 0);

      repeat (3) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule